// File: doc/BRIEF.md
# Configurable Reset Pulse Generator

This block drives a reset output pin. When its trigger input is raised, for example by a watchdog that has expired, it produces one pulse of programmable length. A single 32-bit configuration word holds three settings: the pulse width, the level the pin takes while the pulse is asserted, and whether the pin is driven push-pull or open-drain. The block provides a pin level output and a pin output-enable output, so that a pad outside the block can model an open-drain connection.

An ordinary write changes only the width field. The polarity bit and the drive-type bit change only when the top byte of the written word holds one of four key values. Any other top byte leaves both bits as they were. This lets software reprogram the width without first reading the word back. The word also reports a busy flag while a pulse is in progress. A trigger that arrives during a pulse is dropped. The width is captured when the pulse starts, so the pulse that is already running keeps its length.

Top module: `rst_pulse_gen`

## Requirements
- R1: After reset the configuration word reads 0x000000FF (width 255, active-low, open-drain, not busy). The pin rests high and the output-enable is low.
- R2: A write always loads bits 19:0 of the data into the width field. Bits 28:20 always read zero.
- R3: A write whose top byte (bits 31:24) is 0xA5 sets bit 31 (pulse asserted high). A top byte of 0x5A clears bit 31 (pulse asserted low).
- R4: A write whose top byte is 0xA8 sets bit 30 (push-pull drive). A top byte of 0x8A clears bit 30 (open-drain drive).
- R5: A write whose top byte is none of the four key values leaves bits 31 and 30 unchanged.
- R6: A trigger sampled high while idle starts a pulse. The pin shows the asserted level from the next cycle for width+1 cycles, then returns to the deasserted level.
- R7: Bit 29 of the read word is high in exactly those cycles in which the pulse is asserted.
- R8: A trigger that arrives while a pulse is running is ignored. Holding the trigger high does not lengthen the pulse.
- R9: The width is captured when the pulse starts. A width write during a pulse affects only later pulses.
- R10: In push-pull mode the output-enable is always high. In open-drain mode the output-enable is high exactly when the pin level is low.
- R11: A width of 0 gives a pulse of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the configuration word |
| wr_data_i | input | 32 | Write data: width in 19:0, key byte in 31:24 |
| rd_data_o | output | 32 | Read data: polarity 31, drive 30, busy 29, width 19:0 |
| trig_i | input | 1 | Pulse start request |
| pin_o | output | 1 | Reset pin level |
| pin_oe_o | output | 1 | Reset pin output-enable |

## Verification
The bench writes each key byte and a non-key top byte with all bits set. A design that stores the whole word, or that decodes only part of the key, shows stray bits in 31:20 or loses polarity. Each pulse is measured cycle by cycle at widths 0, 3, 4 and 5 and at the reset width of 255. An off-by-one counter gives a length that is wrong by one. The bench also holds the trigger high through a whole pulse and writes a new width in the middle of one. A design that restarts on a retrigger, or that reloads the width live, gives a longer or shorter pulse. The output-enable is checked in every sample for each pairing of polarity and drive type. A design that mixes up open-drain and push-pull drives the pin when it should release it.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

    localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
    localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
    localparam logic [7:0] KEY_DRV_PP   = 8'hA8;
    localparam logic [7:0] KEY_DRV_OD   = 8'h8A;

    localparam int POL_BIT  = 31;
    localparam int DRV_BIT  = 30;
    localparam int BUSY_BIT = 29;

    typedef struct packed {
        logic pol_set;
        logic pol_clr;
        logic drv_set;
        logic drv_clr;
    } key_act_t;

    function automatic key_act_t decode_key(input logic [7:0] top);
        key_act_t act;
        act.pol_set = (top == KEY_POL_HIGH);
        act.pol_clr = (top == KEY_POL_LOW);
        act.drv_set = (top == KEY_DRV_PP);
        act.drv_clr = (top == KEY_DRV_OD);
        return act;
    endfunction

endpackage

// File: rtl/rpg_cfg_reg.sv
module rpg_cfg_reg #(
    parameter int DATA_W    = 32,
    parameter int WIDTH_W   = 20,
    parameter int RST_WIDTH = 255
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [WIDTH_W-1:0] width_o,
    output logic               act_high_o,
    output logic               push_pull_o
);
    import rpg_pkg::*;

    typedef struct packed {
        logic               act_high;
        logic               push_pull;
        logic [WIDTH_W-1:0] width;
    } cfg_t;

    cfg_t     cfg_d, cfg_q;
    key_act_t key;

    always_comb begin
        cfg_d = cfg_q;
        key   = decode_key(wr_data_i[DATA_W-1 -: 8]);
        if (wr_en_i) begin
            cfg_d.width = wr_data_i[WIDTH_W-1:0];
            if (key.pol_set) cfg_d.act_high  = 1'b1;
            if (key.pol_clr) cfg_d.act_high  = 1'b0;
            if (key.drv_set) cfg_d.push_pull = 1'b1;
            if (key.drv_clr) cfg_d.push_pull = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q.act_high  <= 1'b0;
            cfg_q.push_pull <= 1'b0;
            cfg_q.width     <= WIDTH_W'(RST_WIDTH);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign width_o     = cfg_q.width;
    assign act_high_o  = cfg_q.act_high;
    assign push_pull_o = cfg_q.push_pull;

    // R2: width field follows the written data
    a_r2_width_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> width_o == $past(wr_data_i[WIDTH_W-1:0]));

    // R3: polarity keys
    a_r3_pol_keys: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_data_i[DATA_W-1 -: 8] == KEY_POL_HIGH) |=> act_high_o);

    // R5: non-key writes keep polarity and drive bits
    a_r5_keep_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_data_i[DATA_W-1 -: 8] != KEY_POL_HIGH
                 && wr_data_i[DATA_W-1 -: 8] != KEY_POL_LOW
                 && wr_data_i[DATA_W-1 -: 8] != KEY_DRV_PP
                 && wr_data_i[DATA_W-1 -: 8] != KEY_DRV_OD)
        |=> $stable(act_high_o) && $stable(push_pull_o));

endmodule

// File: rtl/rpg_pulse_timer.sv
module rpg_pulse_timer #(
    parameter int WIDTH_W = 20
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               trig_i,
    input  logic [WIDTH_W-1:0] width_i,
    output logic               busy_o
);
    localparam logic [WIDTH_W-1:0] ONE = {{(WIDTH_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic               busy;
        logic [WIDTH_W-1:0] left;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (tmr_q.left == '0) tmr_d.busy = 1'b0;
            else                  tmr_d.left = tmr_q.left - ONE;
        end else if (trig_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.left = width_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end

    assign busy_o = tmr_q.busy;

    // R6: an idle trigger starts a pulse loaded with the current width
    a_r6_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && trig_i) |=> busy_o && tmr_q.left == $past(width_i));

    // R8/R9: a running pulse only counts down, whatever arrives
    a_r8_no_extend: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && tmr_q.left != '0) |=> busy_o && tmr_q.left == $past(tmr_q.left) - ONE);

    a_r6_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && tmr_q.left == '0) |=> !busy_o);

endmodule

// File: rtl/rpg_pad_drive.sv
module rpg_pad_drive (
    input  logic busy_i,
    input  logic act_high_i,
    input  logic push_pull_i,
    output logic pin_o,
    output logic pin_oe_o
);
    always_comb begin
        pin_o    = busy_i ? act_high_i : ~act_high_i;
        pin_oe_o = push_pull_i | ~pin_o;
    end
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
    parameter int DATA_W    = 32,
    parameter int WIDTH_W   = 20,
    parameter int RST_WIDTH = 255
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              trig_i,
    output logic              pin_o,
    output logic              pin_oe_o
);
    import rpg_pkg::*;

    localparam int PAD_W = BUSY_BIT - WIDTH_W;

    logic [WIDTH_W-1:0] width;
    logic               act_high;
    logic               push_pull;
    logic               busy;

    rpg_cfg_reg #(.DATA_W(DATA_W), .WIDTH_W(WIDTH_W), .RST_WIDTH(RST_WIDTH)) u_cfg (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .width_o     (width),
        .act_high_o  (act_high),
        .push_pull_o (push_pull)
    );

    rpg_pulse_timer #(.WIDTH_W(WIDTH_W)) u_tmr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .trig_i  (trig_i),
        .width_i (width),
        .busy_o  (busy)
    );

    rpg_pad_drive u_pad (
        .busy_i      (busy),
        .act_high_i  (act_high),
        .push_pull_i (push_pull),
        .pin_o       (pin_o),
        .pin_oe_o    (pin_oe_o)
    );

    always_comb begin
        rd_data_o = '0;
        rd_data_o[WIDTH_W-1:0] = width;
        rd_data_o[BUSY_BIT]    = busy;
        rd_data_o[DRV_BIT]     = push_pull;
        rd_data_o[POL_BIT]     = act_high;
    end

    // R10: output-enable rules
    a_r10_pp_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[DRV_BIT] |-> pin_oe_o);
    a_r10_od_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_data_o[DRV_BIT] |-> (pin_oe_o == !pin_o));

    // R7: busy bit matches asserted pin level
    a_r7_busy_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[BUSY_BIT] |-> (pin_o == rd_data_o[POL_BIT]));

    // R2: bits between width and busy always read zero
    a_r2_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[BUSY_BIT-1 -: PAD_W] == '0);

endmodule

// File: tb/rst_pulse_gen_tb_top.sv
module rst_pulse_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        trig = 1'b0;
    logic        pin;
    logic        pin_oe;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    rst_pulse_gen dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .trig_i    (trig),
        .pin_o     (pin),
        .pin_oe_o  (pin_oe)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; trig = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_word(input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_expect(input logic [31:0] w, input logic [31:0] exp, input string tag);
        write_word(w);
        check(rd_data === exp, tag, rd_data, exp);
    endtask

    // Runs one pulse and checks its length, busy flag and output-enable.
    task automatic run_pulse(input int exp_len, input bit lvl, input bit pp, input bit hold,
                             input int wr_at, input logic [31:0] wr_word, input string tag);
        int  n;
        bit  oe_bad;
        bit  busy_bad;
        n = 0; oe_bad = 0; busy_bad = 0;
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        if (!hold) trig = 1'b0;
        while (pin === lvl && n < 1000) begin
            if (n == wr_at) begin wr_en = 1'b1; wr_data = wr_word; end
            else wr_en = 1'b0;
            if (rd_data[29] !== 1'b1) busy_bad = 1;
            if (pin_oe !== (pp | ~lvl)) oe_bad = 1;
            n++;
            @(negedge clk);
        end
        wr_en = 1'b0;
        trig  = 1'b0;
        check(n == exp_len, {tag, " length"}, n, exp_len);
        check(!busy_bad && rd_data[29] === 1'b0, "R7 busy flag tracks pulse", rd_data, {2'b0, 1'b0, 29'b0});
        check(!oe_bad, "R10 output-enable during pulse", pin_oe, pp | ~lvl);
        check(pin === ~lvl && pin_oe === (pp | lvl), "R10 idle pin and output-enable",
              {30'b0, pin, pin_oe}, {30'b0, ~lvl, pp | lvl});
    endtask

    task automatic t_reset_state();
        check(rd_data === 32'h0000_00FF, "R1 reset word", rd_data, 32'h0000_00FF);
        check(pin === 1'b1 && pin_oe === 1'b0, "R1 reset pin", {30'b0, pin, pin_oe}, 32'h2);
    endtask

    task automatic t_width_writes();
        write_expect(32'h0000_0ABC, 32'h0000_0ABC, "R2 width write");
        write_expect(32'h1FFF_FFFF, 32'h000F_FFFF, "R2 R5 non-key top byte, upper bits zero");
    endtask

    task automatic t_keys();
        write_expect(32'hA500_0005, 32'h8000_0005, "R3 key sets active-high");
        write_expect(32'hA800_0005, 32'hC000_0005, "R4 key sets push-pull");
        write_expect(32'h7700_0007, 32'hC000_0007, "R5 other byte keeps mode");
        write_expect(32'hFF00_0007, 32'hC000_0007, "R5 all-ones byte keeps mode");
        write_expect(32'h5A00_0007, 32'h4000_0007, "R3 key clears active-high");
        write_expect(32'h8A00_0007, 32'h0000_0007, "R4 key clears push-pull");
    endtask

    task automatic t_basic_pulse();
        write_word(32'h0000_0005);
        run_pulse(6, 1'b0, 1'b0, 1'b0, -1, '0, "R6 width 5 active-low open-drain");
    endtask

    task automatic t_zero_width();
        write_word(32'h0000_0000);
        run_pulse(1, 1'b0, 1'b0, 1'b0, -1, '0, "R11 width 0");
    endtask

    task automatic t_retrigger();
        write_word(32'h0000_0004);
        run_pulse(5, 1'b0, 1'b0, 1'b1, -1, '0, "R8 held trigger");
    endtask

    task automatic t_write_mid_pulse();
        write_word(32'h0000_0006);
        run_pulse(7, 1'b0, 1'b0, 1'b0, 2, 32'h0000_0014, "R9 write during pulse");
        check(rd_data === 32'h0000_0014, "R9 new width stored", rd_data, 32'h0000_0014);
        run_pulse(21, 1'b0, 1'b0, 1'b0, -1, '0, "R9 next pulse uses new width");
    endtask

    task automatic t_push_pull_high();
        write_word(32'hA500_0003);
        write_word(32'hA800_0003);
        check(pin === 1'b0 && pin_oe === 1'b1, "R10 push-pull idle", {30'b0, pin, pin_oe}, 32'h1);
        run_pulse(4, 1'b1, 1'b1, 1'b0, -1, '0, "R6 active-high push-pull");
    endtask

    task automatic t_open_drain_high();
        write_word(32'h8A00_0003);
        run_pulse(4, 1'b1, 1'b0, 1'b0, -1, '0, "R6 active-high open-drain");
    endtask

    task automatic t_default_width();
        do_reset();
        run_pulse(256, 1'b0, 1'b0, 1'b0, -1, '0, "R1 R6 reset width 255");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        t_reset_state();
        t_width_writes();
        t_keys();
        t_basic_pulse();
        t_zero_width();
        t_retrigger();
        t_write_mid_pulse();
        t_push_pull_high();
        t_open_drain_high();
        t_default_width();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule